// File: doc/BRIEF.md
# Hit-Driven Readout Sequencer

This controller sits between a group of front-end channels and one shared ADC. Each channel's peak detector latches when it sees a hit and holds a request line high until it is told to clear. The sequencer grants these requests one per cycle in round-robin order. For each grant it queues the channel index with a time stamp in a small digital queue. It then walks the ADC through the queue in order, one conversion at a time.

Each conversion result is sent on a valid/ready output together with the channel index and time stamp it belongs to. Once the word is accepted, the sequencer pulses that channel's clear line and retires the queue entry. It then starts the next queued channel, or powers the ADC down when nothing is waiting. The channel count per ADC is a parameter; with 128 front-end channels shared by 1, 2 or 4 converters, each converter serves 128, 64 or 32 channels. A counter records hits that arrive on a channel that is still locked and queued.

Top module: `hit_seq_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, adc_pwr_o, adc_start_o, out_valid_o and every hit_clr_o bit are 0 and loss_cnt_o is 0.
- R2: Requesting channels that are not yet queued are granted one per cycle. The search starts at the index after the last granted channel and wraps from NUM_CH-1 to 0. The pointer is 0 after reset.
- R3: The time stamp is a counter that is 0 at reset and increments by 1 every cycle. An entry carries the counter value of the cycle in which its channel was granted.
- R4: Channels are converted in queue order. adc_ch_o holds the channel index while adc_start_o pulses, and out_ch_o reports the same index.
- R5: out_data_o equals the adc_data_i value sampled with adc_done_i. It leaves together with that entry's channel index and time stamp.
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o, out_ch_o, out_ts_o and out_data_o hold steady. No new adc_start_o pulse occurs before the word is accepted.
- R7: In the cycle after a word is accepted, hit_clr_o pulses for exactly one cycle with only the bit of that word's channel set. After that clear, the channel may be granted again.
- R8: adc_pwr_o is low whenever the queue is empty and no conversion is in progress. It stays high from one conversion to the next when further entries are queued. adc_start_o pulses only while adc_pwr_o is high.
- R9: When the queue is full, no entry is written. Requests that are still pending stay pending and are granted once space frees.
- R10: loss_cnt_o increases by the number of channels whose hit_evt_i bit is high while that channel is queued. Hits on channels that are not queued leave it unchanged.
- R11: A channel whose request stays high while it is queued is not queued again. One hit yields exactly one output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_req_i | input | NUM_CH | Latched request per channel from the peak detectors |
| hit_evt_i | input | NUM_CH | Raw hit indication per channel, one cycle per hit |
| hit_clr_o | output | NUM_CH | One-cycle clear pulse to a channel's latch |
| adc_pwr_o | output | 1 | ADC enable; low means shutdown |
| adc_start_o | output | 1 | Conversion start pulse |
| adc_ch_o | output | $clog2(NUM_CH) | Channel selected onto the ADC input |
| adc_done_i | input | 1 | Conversion complete, one-cycle pulse |
| adc_data_i | input | DATA_W | Conversion result, valid with adc_done_i |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word accepted when high with valid |
| out_ch_o | output | $clog2(NUM_CH) | Channel index of the output word |
| out_ts_o | output | TS_W | Time stamp of the output word |
| out_data_o | output | DATA_W | Conversion result of the output word |
| loss_cnt_o | output | LOSS_W | Count of hits refused on queued channels |

## Verification
The assertions rely on three assumptions about the environment. The front end keeps a request high until its clear pulse. The ADC raises done only after a start. out_ready_i may change in any cycle. The bench follows these rules with a latch model per channel that drops its request at the clock edge where it sees the clear. Its ADC model answers each start after a fixed latency. Ready is driven either steady or as a random value each cycle, always a little after the rising edge. Hits are raised only on idle channels, except where the loss count is being exercised. In that case the repeated hit goes only to a channel that is already queued, so it must be refused and not queued a second time.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_START,
    ST_CONV,
    ST_OUT,
    ST_CLR
  } seq_state_e;
endpackage

// File: rtl/hsc_rr_arb.sv
module hsc_rr_arb #(
  parameter int N  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          en_i,
  output logic          gnt_vld_o,
  output logic [IW-1:0] gnt_idx_o,
  output logic [N-1:0]  gnt_o
);
  logic [IW-1:0] ptr_q;
  logic          found;
  logic [IW-1:0] idx;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = int'(ptr_q) + i;
      if (k >= N) k = k - N;
      if (!found && req_i[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end

  assign gnt_vld_o = found & en_i;
  assign gnt_idx_o = idx;
  assign gnt_o     = gnt_vld_o ? (N'(1) << idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (gnt_vld_o) begin
      if (int'(idx) == N - 1) ptr_q <= '0;
      else                    ptr_q <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/hsc_fifo.sv
module hsc_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign dout_o  = mem_q[rd_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/hit_seq_ctrl.sv
module hit_seq_ctrl
  import hsc_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int TS_W       = 16,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int LOSS_W     = 16,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hit_req_i,
  input  logic [NUM_CH-1:0] hit_evt_i,
  output logic [NUM_CH-1:0] hit_clr_o,
  output logic              adc_pwr_o,
  output logic              adc_start_o,
  output logic [CH_W-1:0]   adc_ch_o,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CH_W-1:0]   out_ch_o,
  output logic [TS_W-1:0]   out_ts_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [LOSS_W-1:0] loss_cnt_o
);
  localparam int ENT_W = CH_W + TS_W;
  localparam int CW    = $clog2(FIFO_DEPTH) + 1;

  seq_state_e        state_q, state_d;
  logic [TS_W-1:0]   ts_q;
  logic [NUM_CH-1:0] queued_q;
  logic [DATA_W-1:0] data_q;
  logic [LOSS_W-1:0] loss_q;

  logic              fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic [CW-1:0]     fifo_cnt;
  logic [ENT_W-1:0]  fifo_head;
  logic [CH_W-1:0]   gnt_idx, head_ch;
  logic [TS_W-1:0]   head_ts;
  logic [NUM_CH-1:0] gnt;

  // queued channels are masked so a held request is taken once
  hsc_rr_arb #(.N(NUM_CH)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (hit_req_i & ~queued_q),
    .en_i      (~fifo_full),
    .gnt_vld_o (fifo_push),
    .gnt_idx_o (gnt_idx),
    .gnt_o     (gnt)
  );

  hsc_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .din_i   ({gnt_idx, ts_q}),
    .pop_i   (fifo_pop),
    .dout_o  (fifo_head),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .cnt_o   (fifo_cnt)
  );

  assign head_ch  = fifo_head[ENT_W-1:TS_W];
  assign head_ts  = fifo_head[TS_W-1:0];
  assign fifo_pop = (state_q == ST_CLR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (!fifo_empty) state_d = ST_START;
      ST_START: state_d = ST_CONV;
      ST_CONV:  if (adc_done_i) state_d = ST_OUT;
      ST_OUT:   if (out_ready_i) state_d = ST_CLR;
      ST_CLR:   state_d = (fifo_cnt > CW'(1) || fifo_push) ? ST_START : ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CONV && adc_done_i) data_q <= adc_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q     <= '0;
      queued_q <= '0;
    end else begin
      ts_q     <= ts_q + 1'b1;
      queued_q <= (queued_q | gnt) & ~hit_clr_o;
    end
  end

  // hits landing on an already-queued channel are refused and counted
  logic [LOSS_W-1:0] loss_inc;
  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < NUM_CH; i++) n += int'(hit_evt_i[i] & queued_q[i]);
    loss_inc = LOSS_W'(n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) loss_q <= '0;
    else         loss_q <= loss_q + loss_inc;
  end

  assign hit_clr_o   = (state_q == ST_CLR) ? (NUM_CH'(1) << head_ch) : '0;
  assign adc_pwr_o   = (state_q != ST_OFF);
  assign adc_start_o = (state_q == ST_START);
  assign adc_ch_o    = head_ch;
  assign out_valid_o = (state_q == ST_OUT);
  assign out_ch_o    = head_ch;
  assign out_ts_o    = head_ts;
  assign out_data_o  = data_q;
  assign loss_cnt_o  = loss_q;
endmodule

// File: rtl/hsc_chk.sv
module hsc_chk #(
  parameter int NUM_CH = 32,
  parameter int TS_W   = 16,
  parameter int DATA_W = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] hit_clr_i,
  input logic              adc_pwr_i,
  input logic              adc_start_i,
  input logic              out_valid_i,
  input logic              out_ready_i,
  input logic [CH_W-1:0]   out_ch_i,
  input logic [TS_W-1:0]   out_ts_i,
  input logic [DATA_W-1:0] out_data_i,
  input logic              push_i,
  input logic              full_i,
  input logic [NUM_CH-1:0] gnt_i,
  input logic [NUM_CH-1:0] queued_i
);
  a_r6_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |=> out_valid_i && $stable(out_ch_i)
      && $stable(out_ts_i) && $stable(out_data_i));

  a_r6_no_start_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_i |-> !out_valid_i);

  a_r7_clr_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_clr_i) |-> $past(out_valid_i && out_ready_i));

  a_r7_clr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_clr_i));

  a_r8_start_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_i |-> adc_pwr_i);

  a_r9_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_i);

  a_r11_no_requeue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (gnt_i & queued_i) == '0);
endmodule

bind hit_seq_ctrl hsc_chk #(
  .NUM_CH (NUM_CH),
  .TS_W   (TS_W),
  .DATA_W (DATA_W)
) u_hsc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hit_clr_i   (hit_clr_o),
  .adc_pwr_i   (adc_pwr_o),
  .adc_start_i (adc_start_o),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_ch_i    (out_ch_o),
  .out_ts_i    (out_ts_o),
  .out_data_i  (out_data_o),
  .push_i      (fifo_push),
  .full_i      (fifo_full),
  .gnt_i       (gnt),
  .queued_i    (queued_q)
);

// File: tb/hit_seq_ctrl_bench.sv
module hit_seq_ctrl_bench;
  localparam int N  = 32;
  localparam int CW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] hit_set = '0;
  logic [N-1:0] req_q;
  logic [N-1:0] hit_req;
  logic [N-1:0] hit_clr;
  logic         adc_pwr, adc_start, adc_done, out_valid;
  logic         ready = 1'b1;
  logic [CW-1:0] adc_ch, out_ch;
  logic [7:0]   adc_data, out_data;
  logic [15:0]  out_ts, loss_cnt;

  int checks = 0;
  int errors = 0;
  int tb_ts;
  int tb_ptr = 0;
  int loss_exp = 0;
  bit ready_mode = 1'b0;
  bit ready_fix = 1'b1;
  int exp_ch[$];
  int exp_ts[$];

  assign hit_req = req_q | hit_set;

  hit_seq_ctrl u_hit_seq_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .hit_req_i   (hit_req),
    .hit_evt_i   (hit_set),
    .hit_clr_o   (hit_clr),
    .adc_pwr_o   (adc_pwr),
    .adc_start_o (adc_start),
    .adc_ch_o    (adc_ch),
    .adc_done_i  (adc_done),
    .adc_data_i  (adc_data),
    .out_valid_o (out_valid),
    .out_ready_i (ready),
    .out_ch_o    (out_ch),
    .out_ts_o    (out_ts),
    .out_data_o  (out_data),
    .loss_cnt_o  (loss_cnt)
  );

  function automatic int adc_val(input int ch);
    return (ch * 37 + 11) & 255;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // time stamp reference per R3
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_ts <= 0;
    else        tb_ts <= (tb_ts + 1) & 16'hFFFF;

  // peak-detector latch model
  always @(posedge clk or negedge rst_n)
    if (!rst_n) req_q <= '0;
    else        req_q <= (req_q | hit_set) & ~hit_clr;

  // ADC model: result three edges after the start
  int lat = 0;
  int ch_l = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_done <= 1'b0;
      adc_data <= '0;
      lat <= 0;
    end else begin
      adc_done <= 1'b0;
      if (adc_start) begin
        chk(adc_pwr, "R8 start while powered", int'(adc_pwr), 1);
        lat  <= 3;
        ch_l <= int'(adc_ch);
      end else if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          adc_done <= 1'b1;
          adc_data <= 8'(adc_val(ch_l));
        end
      end
    end
  end

  initial forever begin
    @(posedge clk);
    #1;
    ready = ready_mode ? 1'($urandom & 1) : ready_fix;
  end

  // monitor / scoreboard
  bit prev_stall = 0;
  int p_ch, p_ts, p_data;
  int clr_stage = 0;
  int clr_ch = 0;
  int pwr_stage = 0;
  bit pwr_exp = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (clr_stage != 0) begin
        chk(hit_clr == (N'(1) << clr_ch), "R7 clear pulse", int'(hit_clr), 1 << clr_ch);
        clr_stage = 0;
      end
      if (pwr_stage != 0) begin
        pwr_stage--;
        if (pwr_stage == 0)
          chk(adc_pwr == pwr_exp, "R8 power after word", int'(adc_pwr), int'(pwr_exp));
      end
      if (prev_stall)
        chk(out_valid && int'(out_ch) == p_ch && int'(out_ts) == p_ts && int'(out_data) == p_data,
            "R6 stalled word held", int'(out_data), p_data);
      if (out_valid && ready) begin
        if (exp_ch.size() == 0) begin
          chk(1'b0, "R11 unexpected word", int'(out_ch), -1);
        end else begin
          int ec, et;
          ec = exp_ch.pop_front();
          et = exp_ts.pop_front();
          chk(int'(out_ch) == ec, "R4 channel order", int'(out_ch), ec);
          chk(int'(out_data) == adc_val(ec), "R5 data bundled", int'(out_data), adc_val(ec));
          if (et >= 0) chk(int'(out_ts) == et, "R3 time stamp", int'(out_ts), et);
          clr_stage = 1;
          clr_ch = ec;
          pwr_stage = 2;
          pwr_exp = (exp_ch.size() != 0);
        end
      end
      prev_stall = out_valid && !ready;
      p_ch = int'(out_ch);
      p_ts = int'(out_ts);
      p_data = int'(out_data);
    end
  end

  // driver: raise hits, push expected entries in round-robin grant order (R2)
  task automatic hit_mask(input logic [N-1:0] m);
    int k;
    k = 0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = (tb_ptr + i) % N;
      if (m[idx]) begin
        exp_ch.push_back(idx);
        exp_ts.push_back((tb_ts + k) & 16'hFFFF);
        k++;
      end
    end
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = (tb_ptr + i) % N;
      if (m[idx]) tb_ptr = (idx + 1) % N;
    end
    hit_set = m;
    @(negedge clk);
    hit_set = '0;
  endtask

  task automatic hit(input int ch);
    hit_mask(N'(1) << ch);
  endtask

  // hit that must wait for queue space (R9); time stamp not predicted
  task automatic hit_late(input int ch);
    exp_ch.push_back(ch);
    exp_ts.push_back(-1);
    tb_ptr = (ch + 1) % N;
    hit_set = N'(1) << ch;
    @(negedge clk);
    hit_set = '0;
  endtask

  // repeated hit on a queued channel (R10, R11)
  task automatic lost_hit(input int ch);
    loss_exp++;
    hit_set = N'(1) << ch;
    @(negedge clk);
    hit_set = '0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_ch.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    chk(exp_ch.size() == 0, "R11 all words delivered", exp_ch.size(), 0);
    chk(adc_pwr == 1'b0, "R8 idle shutdown", int'(adc_pwr), 0);
    chk(out_valid == 1'b0, "R6 no stray valid", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!adc_pwr && !adc_start && !out_valid && hit_clr == '0, "R1 reset outputs",
        int'({adc_pwr, adc_start, out_valid}), 0);
    chk(loss_cnt == 0, "R1 loss reset", int'(loss_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!adc_pwr && !out_valid, "R1 idle after reset", int'(adc_pwr), 0);

    // single hit, then re-arm of same channel after clear (R7)
    hit(3);
    drain();
    chk(req_q[3] == 1'b0, "R7 latch cleared", int'(req_q[3]), 0);
    hit(3);
    drain();

    // simultaneous hits, wrap of round-robin pointer, random ready (R2, R6)
    ready_mode = 1'b1;
    hit_mask(N'(32'h8000_0421));
    drain();
    hit_mask(N'(32'h4000_0006));
    drain();

    // refused hits on a queued channel (R10, R11)
    ready_mode = 1'b0;
    ready_fix = 1'b0;
    hit(7);
    repeat (10) @(negedge clk);
    chk(out_valid && out_ch == CW'(7), "R6 word waits for ready", int'(out_ch), 7);
    lost_hit(7);
    lost_hit(7);
    @(negedge clk);
    chk(int'(loss_cnt) == loss_exp, "R10 loss count", int'(loss_cnt), loss_exp);
    hit(9);
    @(negedge clk);
    chk(int'(loss_cnt) == loss_exp, "R10 fresh hit not lost", int'(loss_cnt), loss_exp);
    ready_fix = 1'b1;
    drain();

    // queue full: pending requests kept (R9)
    ready_fix = 1'b0;
    hit(1);
    hit(2);
    hit(3);
    hit(4);
    hit_late(5);
    hit_late(6);
    repeat (20) @(negedge clk);
    chk(out_valid && out_ch == CW'(1), "R9 head still waiting", int'(out_ch), 1);
    chk(req_q[5] && req_q[6], "R9 pending kept", int'(req_q[6:5]), 3);
    chk(int'(loss_cnt) == loss_exp, "R10 full not lost", int'(loss_cnt), loss_exp);
    ready_mode = 1'b1;
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule